// File: doc/BRIEF.md
# SPI Single-Register Read Controller

This block is an SPI master that performs one framed register read per request. A request carries a 7-bit register address. The controller drops chip select and waits a programmable guard time. It then clocks out a command byte made of the read flag and the address, followed by an all-zero filler byte. While the filler byte goes out, it captures the slave's reply from MISO. It then waits the guard time again, raises chip select, holds it high for one more guard time, and presents the reply byte together with a one-cycle completion pulse.

The clock idle level and the sampling edge are chosen per frame by two mode bits. A third bit selects whether bytes travel most-significant bit first or least-significant bit first. The same order applies to the command byte and to reassembling the reply. The serial clock is made by dividing the system clock. The half period and the chip-select guard time are both given in system clocks, and a value of zero counts as one. All settings are latched when a request is accepted. While chip select is high, the serial clock sits at its idle level.

Top module: `spi_regrd_ctrl`

## Requirements
- R1: While `spi_cs_n` is high and no frame is in progress, `spi_sclk` equals the `cfg_cpol` value seen at the previous clock edge, so it rests low for CPOL=0 and high for CPOL=1. During the post-frame gap it stays at the latched CPOL level.
- R2: A frame has exactly 32 `spi_sclk` transitions. They are spaced max(`cfg_half_div`,1) system clocks apart. The first edge is rising when CPOL=0 and falling when CPOL=1. For CPHA=0, odd-numbered edges (1st, 3rd, ...) sample; for CPHA=1, even-numbered edges sample.
- R3: For CPHA=0, the first MOSI bit is valid from the cycle chip select falls. For CPHA=1, MOSI stays low until the first edge, which launches the first bit. After that, MOSI changes only on non-sampling edges.
- R4: The first byte on MOSI is {1, addr[6:0]}, with the read flag in bit 7. The second byte is 0x00. With `cfg_lsb_first`=0, bit 7 of each byte goes first; with 1, bit 0 goes first. MOSI is low whenever chip select is high.
- R5: `spi_cs_n` falls on the clock edge that accepts a request. It stays low through both bytes without toggling. The first serial-clock edge comes G = max(`cfg_guard`,1) system clocks after chip select falls, and chip select rises G system clocks after the last edge.
- R6: `done` pulses for one cycle G system clocks after chip select rises. In that same cycle, `rd_data` takes the byte sampled during the second byte, assembled in the selected bit order. At all other times `rd_data` holds its value.
- R7: `busy` rises on acceptance and falls in the cycle `done` is high. Requests made while busy are ignored, and changes to the mode, order, divider and guard inputs during a frame have no effect on that frame. After reset: `busy`=0, `done`=0, `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| cfg_lsb_first | input | 1 | 1: least-significant bit first |
| cfg_half_div | input | CNT_W | System clocks per serial clock half period |
| cfg_guard | input | CNT_W | Chip select setup, hold and gap length in system clocks |
| req_valid | input | 1 | Read request, taken when not busy |
| req_addr | input | 7 | Register address |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Reply byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |

## Verification
A wrong edge counter or timer load shows up at once as a serial-clock level that differs from the cycle-exact reference. This happens on the first misplaced toggle, which is often the very first edge after the setup window. A wrong phase decision shows within one half period as a MOSI change on a sampling edge, or as a wrong first bit at chip-select fall. Capture-order or sampling-edge faults only become visible at the completion pulse, as a wrong reply byte. The slave model therefore sends asymmetric reply values in both bit orders.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } rd_state_e;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FRAME_BITS = 2 * BYTE_W;
  localparam int unsigned EDGE_TOTAL = 2 * FRAME_BITS;

  // Bit idx (0..15) of the outgoing frame: command byte then filler byte.
  function automatic logic frame_bit(input logic [BYTE_W-2:0] addr,
                                     input logic              lsb,
                                     input logic [3:0]        idx);
    logic [BYTE_W-1:0] byte_v;
    logic [2:0]        pos;
    byte_v = idx[3] ? '0 : {1'b1, addr};
    pos    = lsb ? idx[2:0] : (3'(BYTE_W - 1) - idx[2:0]);
    return byte_v[pos];
  endfunction

endpackage

// File: rtl/spi_rd_timer.sv
module spi_rd_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/spi_rd_capture.sv
module spi_rd_capture #(
  parameter int unsigned W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [$clog2(W)-1:0] pos,
  input  logic                 lsb,
  input  logic                 din,
  output logic [W-1:0]         data
);

  localparam int unsigned PW = $clog2(W);

  logic [PW-1:0] slot;
  logic [W-1:0]  data_d;

  always_comb begin
    slot   = lsb ? pos : (PW'(W - 1) - pos);
    data_d = data;
    if (clr)     data_d = '0;
    else if (en) data_d[slot] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else        data <= data_d;
  end

endmodule

// File: rtl/spi_regrd_ctrl.sv
module spi_regrd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               cfg_lsb_first,
  input  logic [CNT_W-1:0]   cfg_half_div,
  input  logic [CNT_W-1:0]   cfg_guard,
  input  logic               req_valid,
  input  logic [BYTE_W-2:0]  req_addr,
  output logic               busy,
  output logic               done,
  output logic [BYTE_W-1:0]  rd_data,
  output logic               spi_cs_n,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso
);

  localparam int unsigned        EDGE_W    = $clog2(EDGE_TOTAL + 1);
  localparam logic [EDGE_W-1:0]  LAST_EDGE = EDGE_W'(EDGE_TOTAL - 1);

  function automatic logic [CNT_W-1:0] span_m1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : (v - 1'b1);
  endfunction

  rd_state_e            state_q, state_d;
  logic                 sclk_q, sclk_d;
  logic                 cs_n_q, cs_n_d;
  logic                 mosi_q, mosi_d;
  logic                 done_q, done_d;
  logic [EDGE_W-1:0]    edge_q, edge_d;
  logic [BYTE_W-1:0]    rd_q;

  logic                 cpha_q, lsb_q;
  logic [BYTE_W-2:0]    addr_q;
  logic [CNT_W-1:0]     half_m1_q, guard_m1_q;

  logic                 accept;
  logic                 tmr_load, tmr_zero;
  logic [CNT_W-1:0]     tmr_val;
  logic                 sample_edge, cap_en;
  logic [3:0]           launch_idx;
  logic [BYTE_W-1:0]    cap_data;

  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign sample_edge = (edge_q[0] == cpha_q);
  assign launch_idx  = cpha_q ? edge_q[4:1] : (edge_q[4:1] + 4'd1);
  assign cap_en      = tmr_zero && !sample_edge ? 1'b0 :
                       (tmr_zero && edge_q[4] &&
                        ((state_q == ST_SETUP) || (state_q == ST_SHIFT)));

  // Frame settings, captured once per accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpha_q     <= 1'b0;
      lsb_q      <= 1'b0;
      addr_q     <= '0;
      half_m1_q  <= '0;
      guard_m1_q <= '0;
    end else if (accept) begin
      cpha_q     <= cfg_cpha;
      lsb_q      <= cfg_lsb_first;
      addr_q     <= req_addr;
      half_m1_q  <= span_m1(cfg_half_div);
      guard_m1_q <= span_m1(cfg_guard);
    end
  end

  spi_rd_timer #(.W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  spi_rd_capture #(.W(BYTE_W)) i_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (cap_en),
    .pos   (edge_q[3:1]),
    .lsb   (lsb_q),
    .din   (spi_miso),
    .data  (cap_data)
  );

  always_comb begin
    state_d  = state_q;
    sclk_d   = sclk_q;
    cs_n_d   = cs_n_q;
    mosi_d   = mosi_q;
    edge_d   = edge_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = guard_m1_q;
    unique case (state_q)
      ST_IDLE: begin
        sclk_d = cfg_cpol;
        if (req_valid) begin
          state_d  = ST_SETUP;
          cs_n_d   = 1'b0;
          edge_d   = '0;
          mosi_d   = cfg_cpha ? 1'b0 : frame_bit(req_addr, cfg_lsb_first, 4'd0);
          tmr_load = 1'b1;
          tmr_val  = span_m1(cfg_guard);
        end
      end
      ST_SETUP, ST_SHIFT: begin
        if (tmr_zero) begin
          sclk_d   = ~sclk_q;
          edge_d   = edge_q + 1'b1;
          tmr_load = 1'b1;
          if (!sample_edge && !(!cpha_q && (edge_q == LAST_EDGE)))
            mosi_d = frame_bit(addr_q, lsb_q, launch_idx);
          if (edge_q == LAST_EDGE) begin
            state_d = ST_HOLD;
            tmr_val = guard_m1_q;
          end else begin
            state_d = ST_SHIFT;
            tmr_val = half_m1_q;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          cs_n_d   = 1'b1;
          mosi_d   = 1'b0;
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = guard_m1_q;
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
      edge_q  <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      mosi_q  <= mosi_d;
      done_q  <= done_d;
      edge_q  <= edge_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (done_d) rd_q <= cap_data;
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rd_data  = rd_q;
  assign spi_cs_n = cs_n_q;
  assign spi_sclk = sclk_q;
  assign spi_mosi = mosi_q;

endmodule

// File: rtl/spi_regrd_ctrl_chk.sv
module spi_regrd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cpol,
  input logic       busy,
  input logic       done,
  input logic [7:0] rd_data,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi
);

  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && !busy && !$past(busy)) |-> (spi_sclk == $past(cfg_cpol)));

  p_sclk_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (spi_sclk != $past(spi_sclk))) |-> (!spi_cs_n && !$past(spi_cs_n)));

  p_mosi_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_mosi);

  p_cs_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $rose(busy));

  p_cs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind spi_regrd_ctrl spi_regrd_ctrl_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_cpol (cfg_cpol),
  .busy     (busy),
  .done     (done),
  .rd_data  (rd_data),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi)
);

// File: tb/test_spi_regrd_ctrl.sv
`timescale 1ns/1ps
module test_spi_regrd_ctrl;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic [CW-1:0] cfg_half_div, cfg_guard;
  logic          req_valid;
  logic [6:0]    req_addr;
  logic          busy, done;
  logic [7:0]    rd_data;
  logic          spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  always #2 clk = ~clk;

  spi_regrd_ctrl #(.CNT_W(CW)) i_spi_regrd_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_half_div(cfg_half_div), .cfg_guard(cfg_guard),
    .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .done(done), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] reply_of(input logic [6:0] a);
    return {a[2:0], a[6:3], 1'b1} ^ 8'hC6;
  endfunction

  function automatic bit pick(input logic [7:0] b, input bit lsb, input int i);
    return lsb ? b[i] : b[7 - i];
  endfunction

  // Reference model state
  bit         m_act, m_done;
  int         t, g_len, h_len, t_last, t_end;
  bit         l_cpol, l_cpha, l_lsb, idle_sclk;
  logic [6:0] l_addr;
  logic [7:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_data = 8'h00; idle_sclk = 0; t = 0;
    end else begin
      m_done = 0;
      if (m_act) begin
        t++;
        if (t == t_end) begin
          m_act = 0; m_done = 1; m_data = reply_of(l_addr);
        end
      end else begin
        idle_sclk = cfg_cpol;
        if (req_valid) begin
          l_cpol = cfg_cpol; l_cpha = cfg_cpha; l_lsb = cfg_lsb_first;
          l_addr = req_addr;
          g_len  = (cfg_guard == 0) ? 1 : int'(cfg_guard);
          h_len  = (cfg_half_div == 0) ? 1 : int'(cfg_half_div);
          t_last = g_len + 1 + 31 * h_len;
          t_end  = t_last + 2 * g_len;
          m_act  = 1; t = 1;
        end
      end
    end
  end

  int  n_e, bidx;
  bit  e_cs, e_sclk, e_mosi, in_frame;

  always @(negedge clk) begin
    if (!finished) begin
      n_e = 0;
      if (m_act && t > g_len) begin
        n_e = (t - g_len - 1) / h_len + 1;
        if (n_e > 32) n_e = 32;
      end
      in_frame = m_act && (t < t_last + g_len);
      e_cs   = !in_frame;
      e_sclk = m_act ? (l_cpol ^ n_e[0]) : idle_sclk;
      if (!l_cpha) bidx = (n_e / 2 > 15) ? 15 : n_e / 2;
      else         bidx = (n_e == 0) ? -1 : (n_e - 1) / 2;
      e_mosi = 0;
      if (in_frame && bidx >= 0)
        e_mosi = pick((bidx < 8) ? {1'b1, l_addr} : 8'h00, l_lsb, bidx % 8);

      if (e_cs && !m_act)
        chk(spi_sclk == e_sclk, "R1", "sclk idle", spi_sclk, e_sclk);
      else
        chk(spi_sclk == e_sclk, "R2", "sclk", spi_sclk, e_sclk);
      if (in_frame && n_e == 0)
        chk(spi_mosi == e_mosi, "R3", "mosi first bit", spi_mosi, e_mosi);
      else
        chk(spi_mosi == e_mosi, "R4", "mosi", spi_mosi, e_mosi);
      chk(spi_cs_n == e_cs, "R5", "cs_n", spi_cs_n, e_cs);
      chk(done == m_done, "R6", "done", done, m_done);
      chk(rd_data == m_data, "R6", "rd_data", rd_data, m_data);
      chk(busy == m_act, "R7", "busy", busy, m_act);

      // Slave: reply byte after an arbitrary first byte, in the frame's bit order
      spi_miso <= (in_frame && bidx >= 0) ?
                  pick((bidx < 8) ? 8'h3C : reply_of(l_addr), l_lsb, bidx % 8) : 1'b0;
    end
  end

  task automatic do_read(input bit cpol, input bit cpha, input bit lsb,
                         input logic [6:0] a, input int g, input int h,
                         input bit poke);
    cfg_cpol = cpol;
    repeat (2) @(negedge clk);
    cfg_cpha = cpha; cfg_lsb_first = lsb;
    cfg_guard = CW'(g); cfg_half_div = CW'(h);
    req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      for (int k = 0; k < 8; k++) begin
        req_valid = 1'b1; req_addr = ~a;
        cfg_cpha = ~cpha; cfg_lsb_first = ~lsb; cfg_cpol = ~cpol;
        cfg_guard = CW'(9); cfg_half_div = CW'(5);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    for (int k = 0; k < 4000; k++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done == 1'b1, "R6", "done seen", done, 1);
    chk(rd_data == reply_of(a), poke ? "R7" : "R6", "reply byte", rd_data, reply_of(a));
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0;
    cfg_half_div = '0; cfg_guard = '0;
    req_valid = 0; req_addr = '0; spi_miso = 0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && busy == 1'b0 && rd_data == 8'h00, "R7", "reset state",
        {spi_cs_n, busy, rd_data}, 10'h200);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(0, 0, 0, 7'h0F, 2, 2, 0);
    do_read(0, 1, 0, 7'h42, 1, 1, 0);
    do_read(1, 0, 1, 7'h15, 3, 3, 0);
    do_read(1, 1, 1, 7'h7F, 4, 1, 0);
    do_read(0, 0, 1, 7'h00, 0, 0, 0);
    do_read(1, 1, 0, 7'h2A, 1, 2, 1);
    do_read(0, 1, 1, 7'h55, 2, 1, 1);
    do_read(1, 0, 0, 7'h33, 1, 1, 0);
    cfg_cpol = 1; repeat (3) @(negedge clk);
    chk(spi_sclk == 1'b1, "R1", "idle follows cpol", spi_sclk, 1);
    cfg_cpol = 0; repeat (3) @(negedge clk);
    chk(spi_sclk == 1'b0, "R1", "idle follows cpol", spi_sclk, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule